// File: doc/BRIEF.md
# Read Prefetch Limit Controller

This block sits beside the read-data queue of a bus bridge. It decides how many Dwords a forwarded read may fetch from the target before fetching stops. When the initiator issues a read, the block is loaded with the command type, the address-space attribute, the cache line size and the start offset. From these it works out a Dword budget. It then counts fetched Dwords against that budget. It also watches for the other events that end fetching early: a target disconnect, a full queue, or, in flow-through mode, the initiator releasing its frame.

Once fetching has stopped, the block tracks delivery to the initiator. It raises a disconnect request on the very transfer that hands over the last fetched Dword. If the initiator ends the transaction while fetched data is still undelivered, the block issues a one-cycle discard pulse and clears its counts. Nonprefetchable reads are held to a single Dword, and the block tells the datapath to forward the initiator's byte enables for them.

Top module: `pf_prefetch_limiter`

## Requirements
- R1: After reset, and whenever no read is in progress, `stop_prefetch`, `disc_with_last`, `fwd_byte_en` and `discard_pulse` are all low.
- R2: Command codes 0 (configuration), 1 (I/O) and 2 (memory read) with `pref_space` low fetch exactly one Dword. `fwd_byte_en` is high for the whole of such a read. For any prefetchable read it stays low.
- R3: Command 2 with `pref_space` high stops fetching at the next cache line boundary when `cls` is 1, 2, 4 or 8. For any other `cls` it stops at the next 16-Dword boundary.
- R4: Command 3 (line read) is always prefetchable and follows the same boundary rule as R3.
- R5: Command 4 (multiple read) is always prefetchable. With `cls` of 1, 2, 4 or 8 it stops at the second cache line boundary after the start offset's aligned line. Otherwise only `queue_full` or another stop event ends it.
- R6: A start offset that already lies on a boundary receives a full aligned block, never zero Dwords.
- R7: With `flow_mode` high, a prefetchable read stops at the next 1024-Dword boundary, or in the first cycle `frame_active` is sampled low. With `flow_mode` low, `frame_active` has no effect on fetching.
- R8: A sampled `tgt_disconnect` or `queue_full` stops fetching at the current count, counting any Dword fetched in that same cycle.
- R9: `stop_prefetch` is high from the cycle after the clock edge at which the Dword count reaches the budget. Fetch pulses that arrive after the stop do not add to the count.
- R10: After a stop, `disc_with_last` is high exactly while one fetched Dword remains undelivered. Delivering that Dword returns the block to idle.
- R11: `init_end` with undelivered Dwords gives a one-cycle `discard_pulse` in the following cycle and returns the block to idle. `init_end` with nothing undelivered gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_start | input | 1 | Starts a read when idle; the read attributes are sampled with it |
| rd_cmd | input | 3 | 0 config, 1 I/O, 2 memory, 3 line, 4 multiple |
| pref_space | input | 1 | Address lies in prefetchable memory space |
| cls | input | CLSW | Cache line size in Dwords |
| addr_ofs | input | log2(FT_DW) | Start Dword offset within the 1024-Dword page |
| flow_mode | input | 1 | Flow-through operation |
| frame_active | input | 1 | Initiator frame asserted (high = asserted) |
| tgt_disconnect | input | 1 | Target disconnected the prefetch |
| queue_full | input | 1 | Read queue can take no more data |
| dword_fetched | input | 1 | One Dword accepted from the target this cycle |
| dword_delivered | input | 1 | One Dword handed to the initiator this cycle |
| init_end | input | 1 | Initiator ended the transaction |
| stop_prefetch | output | 1 | Fetching must stop |
| fwd_byte_en | output | 1 | Forward initiator byte enables to the target |
| disc_with_last | output | 1 | Signal target disconnect on the current data transfer |
| discard_pulse | output | 1 | Drop leftover fetched data (one cycle) |

## Verification
A wrong budget register or a miscounted fetch shows up as `stop_prefetch` rising one or more cycles too early or too late, visible in the cycle after the offending fetch. A corrupted mode register shows up in `fwd_byte_en` from the first cycle after `rd_start`. A drifted delivery count moves `disc_with_last` off the final transfer by at least one delivery, or leaves the block stuck out of idle. A lost transaction end shows as a missing or doubled `discard_pulse` one cycle after `init_end`.

// File: rtl/pf_limit_pkg.sv
package pf_limit_pkg;

  typedef enum logic [2:0] {
    RD_CFG  = 3'd0,
    RD_IO   = 3'd1,
    RD_MEM  = 3'd2,
    RD_LINE = 3'd3,
    RD_MULT = 3'd4
  } rd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRAIN = 2'd2
  } pf_state_e;

  typedef struct packed {
    logic nonpref;    // single Dword, byte enables forwarded
    logic flow;       // flow-through: frame release also ends fetching
    logic unbounded;  // no Dword budget, queue-full limited
  } pf_mode_t;

endpackage

// File: rtl/pf_limit_calc.sv
module pf_limit_calc
  import pf_limit_pkg::*;
#(
  parameter int CLSW   = 8,
  parameter int BLK_DW = 16,
  parameter int FT_DW  = 1024,
  parameter int LW     = $clog2(FT_DW) + 1
) (
  input  rd_cmd_e                    cmd,
  input  logic                       pref_space,
  input  logic [CLSW-1:0]            cls,
  input  logic [$clog2(FT_DW)-1:0]   addr_ofs,
  input  logic                       flow_en,
  output pf_mode_t                   mode,
  output logic [LW-1:0]              limit
);
  localparam int BLKB = $clog2(BLK_DW);
  localparam int FTB  = $clog2(FT_DW);

  logic          cls_pow;
  logic [LW-1:0] cls_l, addr_l, off_cl, lim_blk, lim_cl, lim_2cl, lim_ft;

  always_comb begin
    cls_pow = (cls == CLSW'(1)) || (cls == CLSW'(2)) ||
              (cls == CLSW'(4)) || (cls == CLSW'(8));
    cls_l   = {{(LW-4){1'b0}}, cls[3:0]};
    addr_l  = {{(LW-FTB){1'b0}}, addr_ofs};
    off_cl  = addr_l & (cls_l - 1'b1);
    lim_blk = LW'(BLK_DW) - {{(LW-BLKB){1'b0}}, addr_ofs[BLKB-1:0]};
    lim_cl  = cls_l - off_cl;
    lim_2cl = (cls_l << 1) - off_cl;
    lim_ft  = LW'(FT_DW) - addr_l;

    mode  = '0;
    limit = LW'(1);
    unique case (cmd)
      RD_MEM: begin
        mode.nonpref = ~pref_space;
        limit        = ~pref_space ? LW'(1) : (cls_pow ? lim_cl : lim_blk);
      end
      RD_LINE: limit = cls_pow ? lim_cl : lim_blk;
      RD_MULT: begin
        limit          = cls_pow ? lim_2cl : lim_blk;
        mode.unbounded = ~cls_pow;
      end
      default: mode.nonpref = 1'b1;  // config, I/O and unused codes
    endcase

    if (flow_en && !mode.nonpref) begin
      mode.flow      = 1'b1;
      mode.unbounded = 1'b0;
      limit          = lim_ft;
    end
  end

endmodule

// File: rtl/pf_dword_tracker.sv
module pf_dword_tracker #(
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fetch_en,
  input  logic          deliver_en,
  output logic [LW-1:0] fetched,
  output logic [LW-1:0] delivered,
  output logic [LW-1:0] leftover
);
  logic [LW-1:0] fetched_d, delivered_d;

  assign leftover = fetched - delivered;

  always_comb begin
    fetched_d   = fetched;
    delivered_d = delivered;
    if (clr) begin
      fetched_d   = '0;
      delivered_d = '0;
    end else begin
      if (fetch_en && (fetched != '1))        fetched_d   = fetched + 1'b1;
      if (deliver_en && (leftover != '0))     delivered_d = delivered + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetched   <= '0;
      delivered <= '0;
    end else begin
      fetched   <= fetched_d;
      delivered <= delivered_d;
    end
  end

  AST_DELIVER_LE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    delivered <= fetched);  // R10

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fetched == '0 && delivered == '0));  // R11

endmodule

// File: rtl/pf_prefetch_limiter.sv
module pf_prefetch_limiter
  import pf_limit_pkg::*;
#(
  parameter int CLSW   = 8,
  parameter int BLK_DW = 16,
  parameter int FT_DW  = 1024
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_start,
  input  logic [2:0]                rd_cmd,
  input  logic                      pref_space,
  input  logic [CLSW-1:0]           cls,
  input  logic [$clog2(FT_DW)-1:0]  addr_ofs,
  input  logic                      flow_mode,
  input  logic                      frame_active,
  input  logic                      tgt_disconnect,
  input  logic                      queue_full,
  input  logic                      dword_fetched,
  input  logic                      dword_delivered,
  input  logic                      init_end,
  output logic                      stop_prefetch,
  output logic                      fwd_byte_en,
  output logic                      disc_with_last,
  output logic                      discard_pulse
);
  localparam int LW = $clog2(FT_DW) + 1;

  pf_state_e     st_q, st_d;
  pf_mode_t      mode_q, mode_d, calc_mode;
  logic [LW-1:0] limit_q, limit_d, calc_limit;
  logic          discard_q, discard_d;
  logic          clr, fetch_en, deliver_en, hit, stop_evt;
  logic [LW-1:0] fetched, delivered, leftover;
  logic [LW:0]   fetch_nx;

  pf_limit_calc #(.CLSW(CLSW), .BLK_DW(BLK_DW), .FT_DW(FT_DW), .LW(LW)) calc_i (
    .cmd(rd_cmd_e'(rd_cmd)), .pref_space(pref_space), .cls(cls),
    .addr_ofs(addr_ofs), .flow_en(flow_mode), .mode(calc_mode), .limit(calc_limit)
  );

  pf_dword_tracker #(.LW(LW)) trk_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fetch_en(fetch_en),
    .deliver_en(deliver_en), .fetched(fetched), .delivered(delivered),
    .leftover(leftover)
  );

  assign fetch_nx = {1'b0, fetched} + 1'b1;
  assign hit      = !mode_q.unbounded && dword_fetched && (fetch_nx >= {1'b0, limit_q});
  assign stop_evt = hit || tgt_disconnect || queue_full || (mode_q.flow && !frame_active);

  always_comb begin
    st_d       = st_q;
    mode_d     = mode_q;
    limit_d    = limit_q;
    discard_d  = 1'b0;
    clr        = 1'b0;
    fetch_en   = 1'b0;
    deliver_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (rd_start) begin
        st_d    = ST_FETCH;
        mode_d  = calc_mode;
        limit_d = calc_limit;
        clr     = 1'b1;
      end
      ST_FETCH: if (init_end) begin
        discard_d = (leftover != '0);
        clr       = 1'b1;
        st_d      = ST_IDLE;
      end else begin
        fetch_en   = dword_fetched;
        deliver_en = dword_delivered;
        if (stop_evt) st_d = ST_DRAIN;
      end
      ST_DRAIN: if (init_end) begin
        discard_d = (leftover != '0);
        clr       = 1'b1;
        st_d      = ST_IDLE;
      end else if (dword_delivered && leftover == LW'(1)) begin
        clr  = 1'b1;
        st_d = ST_IDLE;
      end else begin
        deliver_en = dword_delivered;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mode_q    <= '0;
      limit_q   <= '0;
      discard_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      mode_q    <= mode_d;
      limit_q   <= limit_d;
      discard_q <= discard_d;
    end
  end

  assign stop_prefetch  = (st_q == ST_DRAIN);
  assign fwd_byte_en    = (st_q != ST_IDLE) && mode_q.nonpref;
  assign disc_with_last = (st_q == ST_DRAIN) && (leftover == LW'(1));
  assign discard_pulse  = discard_q;

  AST_ONE_DWORD_NONPREF: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_byte_en |-> (fetched <= LW'(1)));  // R2

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && !mode_q.unbounded) |-> (fetched <= limit_q));  // R6

  AST_STOP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH && !init_end && dword_fetched && !mode_q.unbounded &&
     fetch_nx == {1'b0, limit_q}) |=> stop_prefetch);  // R9

  AST_STOP_ON_DISC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH && !init_end && tgt_disconnect) |=> stop_prefetch);  // R8

  AST_STOP_FREEZES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_prefetch && !init_end) |=> (fetched == $past(fetched) || fetched == '0));  // R9

  AST_DISCARD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    discard_pulse |=> !discard_pulse);  // R11

  AST_DISCARD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    discard_pulse |-> (!stop_prefetch && fetched == '0));  // R11

endmodule

// File: tb/pf_prefetch_limiter_tb.sv
`timescale 1ns/1ps
module pf_prefetch_limiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_start = 0, pref_space = 0, flow_mode = 0, frame_active = 1;
  logic [2:0] rd_cmd = 0;
  logic [7:0] cls = 0;
  logic [9:0] addr_ofs = 0;
  logic       tgt_disconnect = 0, queue_full = 0, dword_fetched = 0;
  logic       dword_delivered = 0, init_end = 0;
  logic       stop_prefetch, fwd_byte_en, disc_with_last, discard_pulse;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;  // 125 MHz

  pf_prefetch_limiter dut_i (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_cmd(rd_cmd),
    .pref_space(pref_space), .cls(cls), .addr_ofs(addr_ofs),
    .flow_mode(flow_mode), .frame_active(frame_active),
    .tgt_disconnect(tgt_disconnect), .queue_full(queue_full),
    .dword_fetched(dword_fetched), .dword_delivered(dword_delivered),
    .init_end(init_end), .stop_prefetch(stop_prefetch),
    .fwd_byte_en(fwd_byte_en), .disc_with_last(disc_with_last),
    .discard_pulse(discard_pulse)
  );

  // ---------------- behavioural reference ----------------
  function automatic int ref_limit(input int cmd, input bit pref, input int cl,
                                   input int a, input bit flow,
                                   output bit np, output bit ft);
    bit pw;
    np = (cmd == 0) || (cmd == 1) || (cmd == 2 && !pref);
    ft = flow && !np;
    if (np) return 1;
    if (ft) return 1024 - (a % 1024);
    pw = (cl == 1) || (cl == 2) || (cl == 4) || (cl == 8);
    if (cmd == 4) return pw ? (2 * cl - (a % cl)) : -1;
    return pw ? (cl - (a % cl)) : (16 - (a % 16));
  endfunction

  bit m_act, m_stp, m_np, m_ft, m_dis;
  int m_f, m_d, m_lim, old_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_stp = 0; m_np = 0; m_ft = 0; m_dis = 0;
      m_f = 0; m_d = 0; m_lim = 0;
    end else begin
      m_dis = 0;
      old_left = m_f - m_d;
      if (!m_act) begin
        if (rd_start) begin
          m_lim = ref_limit(rd_cmd, pref_space, cls, addr_ofs, flow_mode, m_np, m_ft);
          m_act = 1; m_stp = 0; m_f = 0; m_d = 0;
        end
      end else if (init_end) begin
        m_dis = (old_left > 0);
        m_act = 0; m_stp = 0; m_f = 0; m_d = 0;
      end else if (!m_stp) begin
        if (dword_fetched) m_f++;
        if (dword_delivered && old_left > 0) m_d++;
        if (tgt_disconnect || queue_full || (m_ft && !frame_active) ||
            (dword_fetched && m_lim > 0 && m_f >= m_lim)) m_stp = 1;
      end else begin
        if (dword_delivered && old_left == 1) begin
          m_act = 0; m_stp = 0; m_f = 0; m_d = 0;
        end else if (dword_delivered && old_left > 0) m_d++;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_stop, e_disc, e_be;
      e_stop = m_act && m_stp;
      e_disc = m_act && m_stp && (m_f - m_d == 1);
      e_be   = m_act && m_np;
      checks++;
      if (stop_prefetch !== e_stop || disc_with_last !== e_disc ||
          fwd_byte_en !== e_be || discard_pulse !== m_dis) begin
        fails++;
        $display("FAIL %s cycle compare: stop=%b/%b disc=%b/%b be=%b/%b discard=%b/%b (actual/expected)",
                 cur_tag, stop_prefetch, e_stop, disc_with_last, e_disc,
                 fwd_byte_en, e_be, discard_pulse, m_dis);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic start_rd(input int cmd, input bit pref, input int cl, input int a, input bit flow);
    @(negedge clk);
    rd_cmd = 3'(cmd); pref_space = pref; cls = 8'(cl); addr_ofs = 10'(a);
    flow_mode = flow; rd_start = 1;
    @(negedge clk);
    rd_start = 0;
  endtask

  task automatic count_to_stop(output int n);
    n = 0;
    dword_fetched = 1;
    while (n < 2000) begin
      @(negedge clk);
      n++;
      if (stop_prefetch) break;
    end
    dword_fetched = 0;
  endtask

  task automatic fetch_n(input int n);
    dword_fetched = 1;
    repeat (n) @(negedge clk);
    dword_fetched = 0;
  endtask

  task automatic drain_all(input int left, input string tag);
    for (int i = 0; i < left; i++) begin
      chk(tag, "disc_with_last before delivery", disc_with_last, (i == left - 1) ? 1 : 0);
      dword_delivered = 1;
      @(negedge clk);
    end
    dword_delivered = 0;
    chk(tag, "stop_prefetch after final delivery", stop_prefetch, 0);
  endtask

  task automatic end_init(input int exp_discard, input string tag);
    init_end = 1;
    @(negedge clk);
    init_end = 0;
    chk(tag, "discard_pulse after init_end", discard_pulse, exp_discard);
    @(negedge clk);
    chk(tag, "discard_pulse second cycle", discard_pulse, 0);
    chk(tag, "stop_prefetch idle", stop_prefetch, 0);
  endtask

  task automatic limit_case(input int cmd, input bit pref, input int cl, input int a,
                            input bit flow, input int exp_n, input string tag);
    int n;
    cur_tag = tag;
    start_rd(cmd, pref, cl, a, flow);
    count_to_stop(n);
    chk(tag, "Dwords fetched before stop", n, exp_n);
    drain_all(exp_n, tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int n;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_tag = "R1";
    chk("R1", "stop after reset", stop_prefetch, 0);
    chk("R1", "be after reset", fwd_byte_en, 0);
    chk("R1", "disc after reset", disc_with_last, 0);
    chk("R1", "discard after reset", discard_pulse, 0);

    // R2: single-Dword reads and byte-enable forwarding
    cur_tag = "R2";
    start_rd(0, 0, 8, 'h13, 0);
    chk("R2", "fwd_byte_en config read", fwd_byte_en, 1);
    count_to_stop(n);
    chk("R2", "config read Dwords", n, 1);
    drain_all(1, "R2");
    limit_case(1, 1, 8, 'h20, 1, 1, "R2");   // I/O ignores space and flow
    limit_case(2, 0, 8, 'h05, 0, 1, "R2");   // memory, nonprefetchable

    // R3: plain memory read, prefetchable
    cur_tag = "R3";
    start_rd(2, 1, 8, 'h23, 0);
    chk("R3", "fwd_byte_en prefetchable", fwd_byte_en, 0);
    count_to_stop(n);
    chk("R3", "cls 8 Dwords", n, 5);
    drain_all(5, "R3");
    limit_case(2, 1, 6, 'h23, 0, 13, "R3");

    // R4: line read
    limit_case(3, 0, 4, 'h42, 0, 2, "R4");
    limit_case(3, 0, 0, 'h4F, 0, 1, "R4");

    // R6: aligned start gets a full block
    limit_case(3, 0, 4, 'h40, 0, 4, "R6");
    limit_case(2, 1, 6, 'h20, 0, 16, "R6");
    limit_case(4, 0, 8, 'h18, 0, 16, "R6");

    // R5: multiple read
    limit_case(4, 0, 2, 'h11, 0, 3, "R5");
    cur_tag = "R5";
    start_rd(4, 0, 16, 0, 0);
    fetch_n(20);
    chk("R5", "no stop before queue full", stop_prefetch, 0);
    queue_full = 1;
    @(negedge clk);
    queue_full = 0;
    chk("R5", "stop on queue full", stop_prefetch, 1);
    drain_all(20, "R5");

    // R7: flow-through
    limit_case(2, 1, 8, 'h3F0, 1, 16, "R7");
    cur_tag = "R7";
    start_rd(3, 0, 4, 0, 1);
    fetch_n(5);
    chk("R7", "still fetching past line in flow mode", stop_prefetch, 0);
    frame_active = 0;
    @(negedge clk);
    frame_active = 1;
    chk("R7", "stop on frame release", stop_prefetch, 1);
    drain_all(5, "R7");
    frame_active = 0;                        // ignored without flow mode
    limit_case(2, 1, 8, 0, 0, 8, "R7");
    frame_active = 1;

    // R8: target disconnect before the boundary
    cur_tag = "R8";
    start_rd(2, 1, 8, 0, 0);
    fetch_n(3);
    tgt_disconnect = 1;
    @(negedge clk);
    tgt_disconnect = 0;
    chk("R8", "stop on target disconnect", stop_prefetch, 1);
    drain_all(3, "R8");

    // R9: fetch pulses after the stop are not counted
    cur_tag = "R9";
    start_rd(2, 1, 4, 1, 0);
    count_to_stop(n);
    chk("R9", "Dwords before stop", n, 3);
    fetch_n(4);
    chk("R9", "stop held", stop_prefetch, 1);
    drain_all(3, "R9");

    // R10: interleaved delivery, disconnect on last transfer
    cur_tag = "R10";
    start_rd(3, 0, 8, 0, 0);
    dword_fetched = 1; dword_delivered = 1;
    repeat (4) @(negedge clk);
    dword_delivered = 0;
    repeat (4) @(negedge clk);
    dword_fetched = 0;
    chk("R10", "stopped after line", stop_prefetch, 1);
    drain_all(5, "R10");

    // R11: transaction ended by the initiator
    cur_tag = "R11";
    start_rd(2, 1, 8, 0, 0);
    fetch_n(4);
    dword_delivered = 1;
    @(negedge clk);
    dword_delivered = 0;
    end_init(1, "R11");
    start_rd(2, 1, 8, 0, 0);
    tgt_disconnect = 1;
    @(negedge clk);
    tgt_disconnect = 0;
    chk("R11", "stopped with nothing fetched", stop_prefetch, 1);
    chk("R11", "no last-transfer disconnect", disc_with_last, 0);
    end_init(0, "R11");
    start_rd(4, 0, 8, 3, 0);
    fetch_n(2);
    end_init(1, "R11");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule